// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

A 32-bit general-purpose I/O controller attached to a plain word-wide register bus. Software programs which pins drive, what they drive, which pins raise interrupts and on which edge. Each driven bit may be taken either from the software output register or from a matching auxiliary input, and the block presents the pad output value together with a per-bit output enable to the pad ring.

Pad inputs are captured on sampling events. By default a sampling event occurs on every system clock. Software may instead select an external clock pin; that pin is synchronised into the system clock domain and a small state machine turns each chosen edge (rising or falling) into a one-cycle sampling pulse. On each sampling event the captured inputs are compared with the previous sample, and edges of the programmed polarity on enabled bits are accumulated in a sticky status register that drives a level interrupt line.

The sampling state machine has three states: `SMP_SYS` (system-clock sampling, pulse every cycle), `SMP_EXT_LO` and `SMP_EXT_HI` (external mode, tracking the synchronised external level). Transitions: `SMP_SYS` goes to `SMP_EXT_HI` or `SMP_EXT_LO` according to the synchronised level when external mode is selected; `SMP_EXT_LO` goes to `SMP_EXT_HI` on a synchronised rise; `SMP_EXT_HI` goes to `SMP_EXT_LO` on a synchronised fall; either external state returns to `SMP_SYS` when external mode is deselected. A rising-edge pulse is issued on the `SMP_EXT_LO` to `SMP_EXT_HI` move, a falling-edge pulse on the reverse move.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: The word index `bus_waddr` (byte offset bits 4:2) selects: 0 input, 1 output, 2 output enable, 3 interrupt enable, 4 trigger polarity, 5 auxiliary select, 6 control, 7 interrupt status; a write with `bus_we` high takes effect at the clock edge, and indices 1 to 7 read back the value last written (control reads back only its bits 3:0, upper bits zero).
- R2: Reading index 0 returns the captured input OR the output register; writes to index 0 change nothing.
- R3: On a sampling event the captured input becomes `pad_in` with every bit whose output enable is 1 forced to 0.
- R4: `pad_oe` equals the output enable register; on a sampling event `pad_out` becomes ((output AND NOT auxsel) OR (`aux_in` AND auxsel)) AND output enable, and holds between events.
- R5: On a sampling event a bit qualifies when it went 0 to 1 with its polarity bit 1, or 1 to 0 with its polarity bit 0, comparing the new capture with the previous capture.
- R6: A bit qualifies only when control bit 2 (global interrupt enable) and that bit's interrupt enable are both 1.
- R7: Qualifying bits are ORed into the status register and control bit 3 (pending) is set in the same cycle; both stay set until software writes them.
- R8: `irq` is high whenever any status bit is 1; writing zero to the status register drops `irq` after that edge, and a qualifying edge sampled at the same edge as a status write is ORed into the written value.
- R9: With control bit 0 set and bit 1 clear, sampling occurs only once per rising edge of `ext_clk`, at the third system clock edge after the transition; falling edges cause no sampling.
- R10: With control bits 0 and 1 set, sampling occurs only once per falling edge of `ext_clk`, at the third system clock edge after the transition; rising edges cause no sampling.
- R11: In external mode, input changes between sampling events neither alter the captured input nor raise status bits.
- R12: Asynchronous active-low reset clears every register, so `pad_oe`, `pad_out` and `irq` are 0 and system-clock sampling is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_waddr | input | 3 | Register word index (byte offset bits 4:2) |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| pad_in | input | 32 | Pad input levels |
| aux_in | input | 32 | Auxiliary output sources |
| ext_clk | input | 1 | External sampling clock pin |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions watch, every cycle, that a write to the input index leaves the capture untouched, that captured inputs and driven outputs respect the output enable in force at the sampling edge, that status bits move only on a sampling event or a status write, that `irq` rises only for one of those causes, and that in external mode no sampling pulse appears while the synchronised pin level is steady. Only the bench scenarios show the actual values: the auxiliary mux result, the polarity and enable gating of edges, the three-cycle external-edge latency for each edge choice, the sticky pending flag, the write-versus-edge collision on the status register and register read-back.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    // Register word indices; software sees them at byte offset index*4.
    localparam int unsigned IDX_W     = 3;
    localparam logic [IDX_W-1:0] RI_IN    = 3'd0;
    localparam logic [IDX_W-1:0] RI_OUT   = 3'd1;
    localparam logic [IDX_W-1:0] RI_OE    = 3'd2;
    localparam logic [IDX_W-1:0] RI_IEN   = 3'd3;
    localparam logic [IDX_W-1:0] RI_POL   = 3'd4;
    localparam logic [IDX_W-1:0] RI_AUX   = 3'd5;
    localparam logic [IDX_W-1:0] RI_CTRL  = 3'd6;
    localparam logic [IDX_W-1:0] RI_STAT  = 3'd7;

    // Control register fields.
    localparam int unsigned CTRL_W    = 4;
    localparam int unsigned CB_EXT    = 0;
    localparam int unsigned CB_FALL   = 1;
    localparam int unsigned CB_GIEN   = 2;
    localparam int unsigned CB_PEND   = 3;

    typedef enum logic [1:0] {
        SMP_SYS    = 2'd0,
        SMP_EXT_LO = 2'd1,
        SMP_EXT_HI = 2'd2
    } smp_state_e;

endpackage

// File: rtl/gpio_edge_sampler.sv
module gpio_edge_sampler
    import gpio_edge_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk,
    input  logic use_ext,
    input  logic fall_sel,
    output logic ext_lvl,
    output logic sample_en
);

    logic [SYNC_STAGES-1:0] sync_q;
    smp_state_e             state_q;
    smp_state_e             state_d;

    // Synchroniser chain for the external clock pin.
    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= ext_clk;
            end
        end else begin : g_syncn
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], ext_clk};
            end
        end
    endgenerate

    assign ext_lvl = sync_q[SYNC_STAGES-1];

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SMP_SYS;
        else        state_q <= state_d;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SMP_SYS: begin
                if (use_ext) state_d = ext_lvl ? SMP_EXT_HI : SMP_EXT_LO;
            end
            SMP_EXT_LO: begin
                if (!use_ext)    state_d = SMP_SYS;
                else if (ext_lvl) state_d = SMP_EXT_HI;
            end
            SMP_EXT_HI: begin
                if (!use_ext)     state_d = SMP_SYS;
                else if (!ext_lvl) state_d = SMP_EXT_LO;
            end
            default: state_d = SMP_SYS;
        endcase
    end

    // Output logic: one pulse per selected external edge, or every cycle.
    always_comb begin
        sample_en = 1'b0;
        unique case (state_q)
            SMP_SYS:    sample_en = 1'b1;
            SMP_EXT_LO: sample_en = use_ext &  ext_lvl & ~fall_sel;
            SMP_EXT_HI: sample_en = use_ext & ~ext_lvl &  fall_sel;
            default:    sample_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic [DATA_W-1:0] pad_in,
    input  logic [DATA_W-1:0] oe,
    input  logic [DATA_W-1:0] pol,
    input  logic [DATA_W-1:0] ien,
    input  logic              gien,
    output logic [DATA_W-1:0] in_q,
    output logic [DATA_W-1:0] qual
);

    logic [DATA_W-1:0] cap_d;
    logic [DATA_W-1:0] rose;
    logic [DATA_W-1:0] fell;

    assign cap_d = pad_in & ~oe;
    assign rose  = cap_d & ~in_q;
    assign fell  = in_q & ~cap_d;

    // Edge qualification, valid only on a sampling event.
    always_comb begin
        qual = '0;
        if (sample_en && gien) begin
            qual = ((rose & pol) | (fell & ~pol)) & ien;
        end
    end

    // Capture register doubles as the previous sample for the next event.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         in_q <= '0;
        else if (sample_en) in_q <= cap_d;
    end

endmodule

// File: rtl/gpio_edge_outmux.sv
module gpio_edge_outmux #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic [DATA_W-1:0] out_reg,
    input  logic [DATA_W-1:0] aux_sel,
    input  logic [DATA_W-1:0] aux_in,
    input  logic [DATA_W-1:0] oe,
    output logic [DATA_W-1:0] pad_out
);

    logic [DATA_W-1:0] mux_d;

    generate
        for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            assign mux_d[b] = oe[b] & (aux_sel[b] ? aux_in[b] : out_reg[b]);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         pad_out <= '0;
        else if (sample_en) pad_out <= mux_d;
    end

endmodule

// File: rtl/gpio_edge_regs.sv
module gpio_edge_regs
    import gpio_edge_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  bus_waddr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] in_q,
    input  logic [DATA_W-1:0] qual,
    output logic [DATA_W-1:0] out_q,
    output logic [DATA_W-1:0] oe_q,
    output logic [DATA_W-1:0] ien_q,
    output logic [DATA_W-1:0] pol_q,
    output logic [DATA_W-1:0] aux_q,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] stat_q
);

    localparam int unsigned NREG = 1 << IDX_W;

    logic [NREG-1:0]   wr_hit;
    logic              any_qual;
    logic [DATA_W-1:0] stat_base;
    logic [CTRL_W-1:0] ctrl_base;
    logic [CTRL_W-1:0] pend_mask;

    generate
        for (genvar r = 0; r < NREG; r++) begin : g_dec
            assign wr_hit[r] = bus_we && (bus_waddr == IDX_W'(r));
        end
    endgenerate

    assign any_qual  = |qual;
    assign pend_mask = CTRL_W'(1) << CB_PEND;
    assign stat_base = wr_hit[RI_STAT] ? bus_wdata : stat_q;
    assign ctrl_base = wr_hit[RI_CTRL] ? bus_wdata[CTRL_W-1:0] : ctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= '0;
            oe_q   <= '0;
            ien_q  <= '0;
            pol_q  <= '0;
            aux_q  <= '0;
            ctrl_q <= '0;
            stat_q <= '0;
        end else begin
            if (wr_hit[RI_OUT]) out_q <= bus_wdata;
            if (wr_hit[RI_OE])  oe_q  <= bus_wdata;
            if (wr_hit[RI_IEN]) ien_q <= bus_wdata;
            if (wr_hit[RI_POL]) pol_q <= bus_wdata;
            if (wr_hit[RI_AUX]) aux_q <= bus_wdata;
            // New edges win over a same-cycle software write.
            ctrl_q <= any_qual ? (ctrl_base | pend_mask) : ctrl_base;
            stat_q <= stat_base | qual;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_waddr)
            RI_IN:   bus_rdata = in_q | out_q;
            RI_OUT:  bus_rdata = out_q;
            RI_OE:   bus_rdata = oe_q;
            RI_IEN:  bus_rdata = ien_q;
            RI_POL:  bus_rdata = pol_q;
            RI_AUX:  bus_rdata = aux_q;
            RI_CTRL: bus_rdata = DATA_W'(ctrl_q);
            RI_STAT: bus_rdata = stat_q;
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_waddr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] pad_in,
    input  logic [DATA_W-1:0] aux_in,
    input  logic              ext_clk,
    output logic [DATA_W-1:0] pad_out,
    output logic [DATA_W-1:0] pad_oe,
    output logic              irq
);

    logic [DATA_W-1:0] out_q;
    logic [DATA_W-1:0] oe_q;
    logic [DATA_W-1:0] ien_q;
    logic [DATA_W-1:0] pol_q;
    logic [DATA_W-1:0] aux_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [DATA_W-1:0] stat_q;
    logic [DATA_W-1:0] in_q;
    logic [DATA_W-1:0] qual;
    logic              sample_en;
    logic              ext_lvl;

    gpio_edge_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_waddr (bus_waddr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .in_q      (in_q),
        .qual      (qual),
        .out_q     (out_q),
        .oe_q      (oe_q),
        .ien_q     (ien_q),
        .pol_q     (pol_q),
        .aux_q     (aux_q),
        .ctrl_q    (ctrl_q),
        .stat_q    (stat_q)
    );

    gpio_edge_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_clk   (ext_clk),
        .use_ext   (ctrl_q[CB_EXT]),
        .fall_sel  (ctrl_q[CB_FALL]),
        .ext_lvl   (ext_lvl),
        .sample_en (sample_en)
    );

    gpio_edge_detect #(.DATA_W(DATA_W)) u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .pad_in    (pad_in),
        .oe        (oe_q),
        .pol       (pol_q),
        .ien       (ien_q),
        .gien      (ctrl_q[CB_GIEN]),
        .in_q      (in_q),
        .qual      (qual)
    );

    gpio_edge_outmux #(.DATA_W(DATA_W)) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .out_reg   (out_q),
        .aux_sel   (aux_q),
        .aux_in    (aux_in),
        .oe        (oe_q),
        .pad_out   (pad_out)
    );

    assign pad_oe = oe_q;
    assign irq    = |stat_q;

endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        bus_waddr,
    input logic              bus_we,
    input logic              sample_en,
    input logic              ext_lvl,
    input logic              use_ext,
    input logic [DATA_W-1:0] in_q,
    input logic [DATA_W-1:0] oe_q,
    input logic [DATA_W-1:0] stat_q,
    input logic [DATA_W-1:0] pad_out,
    input logic              irq
);

    logic wr_in;
    logic wr_stat;
    assign wr_in   = bus_we && (bus_waddr == 3'd0);
    assign wr_stat = bus_we && (bus_waddr == 3'd7);

    a_r2_in_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_in && !sample_en) |=> $stable(in_q));

    a_r3_capture_masked: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |=> ((in_q & $past(oe_q)) == '0));

    a_r4_drive_masked: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |=> ((pad_out & ~$past(oe_q)) == '0));

    a_r7_status_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_en && !wr_stat) |=> $stable(stat_q));

    a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(sample_en) || $past(wr_stat)));

    a_r11_no_pulse_steady_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (use_ext && $past(use_ext) && $stable(ext_lvl)) |-> !sample_en);

endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_waddr (bus_waddr),
    .bus_we    (bus_we),
    .sample_en (sample_en),
    .ext_lvl   (ext_lvl),
    .use_ext   (ctrl_q[0]),
    .in_q      (in_q),
    .oe_q      (oe_q),
    .stat_q    (stat_q),
    .pad_out   (pad_out),
    .irq       (irq)
);

// File: tb/gpio_edge_ctrl_test.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_waddr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] aux_in = '0;
    logic        ext_clk = 1'b0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic        irq;

    int nvec  = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    gpio_edge_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_waddr(bus_waddr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .aux_in(aux_in), .ext_clk(ext_clk), .pad_out(pad_out),
        .pad_oe(pad_oe), .irq(irq)
    );

    // {index, write data, expected read-back}
    localparam logic [66:0] VEC [0:7] = '{
        {3'd1, 32'hA5A5_0F0F, 32'hA5A5_0F0F},
        {3'd2, 32'hFFFF_0000, 32'hFFFF_0000},
        {3'd3, 32'h0000_FF00, 32'h0000_FF00},
        {3'd4, 32'h0F0F_0F0F, 32'h0F0F_0F0F},
        {3'd5, 32'h00FF_00FF, 32'h00FF_00FF},
        {3'd6, 32'hFFFF_FFF4, 32'h0000_0004},
        {3'd7, 32'h0000_0000, 32'h0000_0000},
        {3'd0, 32'hFFFF_FFFF, 32'hA5A5_0F0F}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        bus_waddr = idx; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] d);
        bus_waddr = idx;
        #1;
        d = bus_rdata;
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        cyc(3);
        // R12: reset state
        chk("R12 pad_oe", pad_oe, 32'h0);
        chk("R12 pad_out", pad_out, 32'h0);
        chk("R12 irq", {31'h0, irq}, 32'h0);
        rst_n = 1'b1;
        cyc(1);
        rd(3'd6, v); chk("R12 ctrl", v, 32'h0);

        // R1 / R2: register table
        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][66:64], VEC[i][63:32]);
            rd(VEC[i][66:64], v);
            chk("R1 R2 readback", v, VEC[i][31:0]);
        end
        wr(3'd1, 0); wr(3'd2, 0); wr(3'd3, 0); wr(3'd4, 0); wr(3'd5, 0); wr(3'd6, 0);

        // R4: auxiliary mux and enable mask
        aux_in = 32'hAAAA_AAAA;
        wr(3'd1, 32'h1234_5678); wr(3'd2, 32'h0000_FFFF); wr(3'd5, 32'h0000_00FF);
        chk("R4 pad_oe", pad_oe, 32'h0000_FFFF);
        cyc(2);
        chk("R4 pad_out", pad_out, 32'h0000_56AA);

        // R3 / R2: capture masked by output enable, read ORs output reg
        pad_in = 32'hFFFF_FFFF;
        cyc(2);
        rd(3'd0, v); chk("R3 R2 input read", v, 32'hFFFF_5678);
        wr(3'd1, 0); wr(3'd2, 0); wr(3'd5, 0);
        pad_in = 0;
        cyc(2);

        // R5 / R7: polarity, status accumulation, pending flag
        wr(3'd4, 32'h0000_010F); wr(3'd3, 32'h0000_00FF); wr(3'd6, 32'h4);
        @(negedge clk); pad_in = 32'h0000_00FF;
        @(negedge clk);
        rd(3'd7, v); chk("R5 rising qualify", v, 32'h0000_000F);
        chk("R8 irq set", {31'h0, irq}, 32'h1);
        rd(3'd6, v); chk("R7 pending set", v, 32'hC);
        pad_in = 0;
        @(negedge clk);
        rd(3'd7, v); chk("R5 falling qualify", v, 32'h0000_00FF);
        wr(3'd7, 0);
        chk("R8 irq cleared", {31'h0, irq}, 32'h0);
        rd(3'd6, v); chk("R7 pending sticky", v, 32'hC);
        wr(3'd6, 32'h4);

        // R6: per-bit and global enables
        pad_in = 32'h0000_0100;
        cyc(2);
        rd(3'd7, v); chk("R6 bit enable off", v, 32'h0);
        wr(3'd6, 0);
        pad_in = 32'h0000_0101;
        cyc(2);
        rd(3'd7, v); chk("R6 global enable off", v, 32'h0);
        chk("R6 irq low", {31'h0, irq}, 32'h0);
        pad_in = 0;
        cyc(2);
        wr(3'd6, 32'h4);

        // R8: write collides with a new edge
        wr(3'd7, 32'h2);
        chk("R8 irq from write", {31'h0, irq}, 32'h1);
        @(negedge clk);
        bus_waddr = 3'd7; bus_wdata = 0; bus_we = 1'b1; pad_in = 32'h1;
        @(negedge clk);
        bus_we = 1'b0;
        rd(3'd7, v); chk("R8 edge kept over write", v, 32'h1);
        pad_in = 0;
        cyc(2);
        wr(3'd7, 0);

        // R9 / R11: external rising edge
        wr(3'd6, 32'h5);
        cyc(4);
        pad_in = 32'h1;
        cyc(5);
        rd(3'd0, v); chk("R11 no sample without edge", v, 32'h0);
        rd(3'd7, v); chk("R11 no status without edge", v, 32'h0);
        @(negedge clk); ext_clk = 1'b1;
        cyc(2);
        rd(3'd7, v); chk("R9 not before third edge", v, 32'h0);
        cyc(1);
        rd(3'd7, v); chk("R9 sampled at third edge", v, 32'h1);
        wr(3'd0, 0);
        rd(3'd0, v); chk("R2 write ignored", v, 32'h1);
        pad_in = 0;
        cyc(2);
        ext_clk = 1'b0;
        cyc(5);
        rd(3'd0, v); chk("R9 falling edge ignored", v, 32'h1);
        wr(3'd7, 0);

        // R10: external falling edge
        wr(3'd6, 32'h7);
        ext_clk = 1'b1;
        cyc(5);
        rd(3'd0, v); chk("R10 rising edge ignored", v, 32'h1);
        ext_clk = 1'b0;
        cyc(2);
        rd(3'd0, v); chk("R10 not before third edge", v, 32'h1);
        cyc(1);
        rd(3'd0, v); chk("R10 sampled on falling", v, 32'h0);
        wr(3'd6, 0);

        // R4 / R12: drive all, then reset
        aux_in = 0;
        wr(3'd1, 32'hFFFF_FFFF); wr(3'd2, 32'hFFFF_FFFF);
        cyc(2);
        chk("R4 full drive", pad_out, 32'hFFFF_FFFF);
        wr(3'd7, 32'h8);
        rst_n = 1'b0;
        cyc(1);
        chk("R12 pad_out after reset", pad_out, 32'h0);
        chk("R12 pad_oe after reset", pad_oe, 32'h0);
        chk("R12 irq after reset", {31'h0, irq}, 32'h0);
        rd(3'd1, v); chk("R12 out reg after reset", v, 32'h0);
        rst_n = 1'b1;
        cyc(2);

        summary();
        $finish;
    end

endmodule